// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one elementary NAND flash bus operation each time software triggers it. Software loads a command byte or an address byte into a register, picks a buffer area and a transfer mode, and writes a one-hot operation code into the trigger register. The engine then drives chip enable, the command and address latch enables, and the write and read strobes of an 8-bit NAND device. A completion flag rises when the operation is over.

Page data moves through an internal byte buffer. The buffer holds four main areas, followed by four spare areas. Software fills the buffer, or reads it back, through a separate byte port while the engine is idle. A data-output operation waits on the device ready/busy line by itself, so software never polls the device. The read-ID and read-status operations issue their own command cycles and leave their results at the start of a main area.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, busy and done are low, nf_ce_n, nf_we_n and nf_re_n are high, nf_cle and nf_ale are low.
- R2: Registers are written with reg_we: reg_addr 0 holds the command byte, 1 the address byte, 2 the area select, 3 the configuration and 4 the trigger. A trigger code of 0x0001 drives the command byte on nf_dq_o with one write strobe while nf_cle is high and nf_ale is low.
- R3: Trigger code 0x0002 drives the address byte with one write strobe while nf_ale is high and nf_cle is low.
- R4: Each write or read strobe is low for exactly LOW_CLKS clocks. Consecutive strobes are separated by at least HIGH_CLKS clocks high. nf_we_n and nf_re_n are never low together.
- R5: Trigger code 0x0004 (data input) sends MAIN_BYTES main bytes and then SPARE_BYTES spare bytes of area k, in order. Main byte j is taken from buffer address k*MAIN_BYTES+j. Spare byte j is taken from AREAS*MAIN_BYTES+k*SPARE_BYTES+j. The host byte port reads with one cycle of latency.
- R6: Trigger code 0x0008 (data output) issues no read strobe while nf_rb_n is low. It then reads the same byte sequence into the same buffer addresses as R5. Done rises only after the device has become ready.
- R7: With configuration bit 2 set, data input and data output move only the SPARE_BYTES spare bytes of area k, and leave the main area untouched.
- R8: Trigger code 0x0010 issues command 0x90, then address 0x00, then reads ID_BYTES bytes into buffer addresses k*MAIN_BYTES onwards.
- R9: Trigger code 0x0020 issues command 0x70, then reads one status byte into buffer address k*MAIN_BYTES.
- R10: Done is set when an operation completes. It stays set until a trigger write with bit 15 clear. Busy is high while an operation runs, and done is low while busy is high.
- R11: A trigger written while busy is ignored. A trigger code that is not one-hot in bits 5:0 starts nothing.
- R12: nf_ce_n is low during every operation. Configuration bit 7 holds nf_ce_n low while the engine is idle.
- R13: A configuration write with bit 6 set aborts any operation on the next clock. It clears busy and done and returns all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| hb_we | input | 1 | Host buffer byte write (idle only) |
| hb_addr | input | BUF_AW | Host buffer byte address |
| hb_wdata | input | 8 | Host buffer write data |
| hb_rdata | output | 8 | Host buffer read data, one cycle after address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion flag (trigger bit 15) |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data to device |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_i | input | 8 | Data from device |
| nf_rb_n | input | 1 | Device ready (high) / busy (low) |

## Verification
The hardest conditions to reach are the ones that overlap a running operation: a second trigger, or an abort, arriving while the engine is parked waiting on ready/busy. The bench creates this window on purpose. It sends the read-confirm command 0x30, which makes the modelled device hold ready/busy low for a fixed time. It then starts a data output and writes the stray trigger, or the abort, inside that wait. Afterwards it checks the device's own logs of command and strobe activity.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  // bus cycle kind carried by one strobe
  typedef enum logic [1:0] {K_CMD, K_ADDR, K_WR, K_RD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_WAITRB, S_FETCH, S_LOAD, S_PULSE} state_e;

  // register select values
  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_AREA = 3'd2;
  localparam logic [2:0] RA_CFG  = 3'd3;
  localparam logic [2:0] RA_TRIG = 3'd4;

  // trigger code bit positions
  localparam int OPB_CMD  = 0;
  localparam int OPB_ADDR = 1;
  localparam int OPB_DIN  = 2;
  localparam int OPB_DOUT = 3;
  localparam int OPB_ID   = 4;
  localparam int OPB_STAT = 5;
  localparam int DONE_BIT = 15;

  // configuration bit positions
  localparam int CFG_SPARE = 2;
  localparam int CFG_RST   = 6;
  localparam int CFG_CE    = 7;
endpackage

// File: rtl/nand_buf_ram.sv
module nand_buf_ram #(
  parameter int DEPTH = 2112,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nand_buf_map.sv
module nand_buf_map #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int AREAS       = 4,
  parameter int AREA_W      = 2,
  parameter int IW          = 10,
  parameter int AW          = 12
) (
  input  logic [AREA_W-1:0] area,
  input  logic [IW-1:0]     idx,
  input  logic              spare_only,
  input  logic              main_only,
  output logic [AW-1:0]     addr
);
  localparam int SPARE_BASE = AREAS * MAIN_BYTES;

  int a;
  always_comb begin
    if (main_only)
      a = int'(area) * MAIN_BYTES + int'(idx);
    else if (spare_only)
      a = SPARE_BASE + int'(area) * SPARE_BYTES + int'(idx);
    else if (int'(idx) < MAIN_BYTES)
      a = int'(area) * MAIN_BYTES + int'(idx);
    else
      a = SPARE_BASE + int'(area) * SPARE_BYTES + int'(idx) - MAIN_BYTES;
    addr = AW'(a);
  end
endmodule

// File: rtl/nand_pulse_gen.sv
module nand_pulse_gen #(
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic active,
  output logic low,
  output logic last_low,
  output logic fin
);
  localparam int MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      low    <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      low    <= 1'b1;
      cnt    <= '0;
    end else if (low) begin
      if (cnt == CW'(LOW_CLKS - 1)) begin
        low <= 1'b0;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end else if (active) begin
      if (cnt == CW'(HIGH_CLKS - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  assign last_low = low && (cnt == CW'(LOW_CLKS - 1));
  assign fin      = active && !low && (cnt == CW'(HIGH_CLKS - 1));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int AREAS       = 4,
  parameter int ID_BYTES    = 4,
  parameter int LOW_CLKS    = 2,
  parameter int HIGH_CLKS   = 2,
  parameter logic [7:0] CMD_READ_ID     = 8'h90,
  parameter logic [7:0] CMD_READ_STATUS = 8'h70,
  localparam int BUF_BYTES = AREAS * (MAIN_BYTES + SPARE_BYTES),
  localparam int BUF_AW    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              hb_we,
  input  logic [BUF_AW-1:0] hb_addr,
  input  logic [7:0]        hb_wdata,
  output logic [7:0]        hb_rdata,
  output logic              busy,
  output logic              done,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dq_o,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_i,
  input  logic              nf_rb_n
);
  localparam int AREA_W   = (AREAS > 1) ? $clog2(AREAS) : 1;
  localparam int XFER_MAX = MAIN_BYTES + SPARE_BYTES;
  localparam int IW       = $clog2(XFER_MAX + 1);

  // ---------------- software registers ----------------
  logic [7:0]        cmd_r, addr_r;
  logic [AREA_W-1:0] area_r;
  logic              spare_en, force_ce;
  logic              unused_bits;
  assign unused_bits = ^reg_wdata[14:8];

  wire soft_rst = reg_we && (reg_addr == RA_CFG) && reg_wdata[CFG_RST];
  wire trig_wr  = reg_we && (reg_addr == RA_TRIG);
  wire [5:0] code = reg_wdata[5:0];
  wire trig_ok  = trig_wr && !busy && $onehot(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_r <= '0; addr_r <= '0; area_r <= '0;
      spare_en <= 1'b0; force_ce <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CMD:  cmd_r  <= reg_wdata[7:0];
        RA_ADDR: addr_r <= reg_wdata[7:0];
        RA_AREA: area_r <= reg_wdata[AREA_W-1:0];
        RA_CFG: begin
          spare_en <= reg_wdata[CFG_SPARE];
          force_ce <= reg_wdata[CFG_CE];
        end
        default: ;
      endcase
    end
  end

  // ---------------- ready/busy synchroniser ----------------
  logic [1:0] rb_q;
  always_ff @(posedge clk) begin
    if (rst) rb_q <= 2'b00;
    else     rb_q <= {rb_q[0], nf_rb_n};
  end

  // ---------------- sequencer ----------------
  state_e            state;
  kind_e             kind;
  logic [IW-1:0]     idx;
  logic [AREA_W-1:0] area_l;
  logic              sp_l, is_id, is_stat, pstart;
  logic [7:0]        dq_r;
  logic              oe_r;
  logic              p_active, p_low, p_last_low, p_fin;
  logic [7:0]        ram_q;

  wire [IW-1:0] last_idx = is_id   ? IW'(ID_BYTES - 1) :
                           is_stat ? '0 :
                           sp_l    ? IW'(SPARE_BYTES - 1) : IW'(XFER_MAX - 1);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state <= S_IDLE; kind <= K_CMD; idx <= '0; area_l <= '0;
      sp_l <= 1'b0; is_id <= 1'b0; is_stat <= 1'b0; pstart <= 1'b0;
      dq_r <= '0; oe_r <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      pstart <= 1'b0;
      if (trig_wr && !reg_wdata[DONE_BIT]) done <= 1'b0;
      case (state)
        S_IDLE: if (trig_ok) begin
          busy    <= 1'b1;
          done    <= 1'b0;
          idx     <= '0;
          area_l  <= area_r;
          sp_l    <= spare_en;
          is_id   <= code[OPB_ID];
          is_stat <= code[OPB_STAT];
          if (code[OPB_CMD] || code[OPB_ID] || code[OPB_STAT]) begin
            kind <= K_CMD; oe_r <= 1'b1; pstart <= 1'b1; state <= S_PULSE;
            dq_r <= code[OPB_ID] ? CMD_READ_ID : code[OPB_STAT] ? CMD_READ_STATUS : cmd_r;
          end else if (code[OPB_ADDR]) begin
            kind <= K_ADDR; oe_r <= 1'b1; pstart <= 1'b1; state <= S_PULSE;
            dq_r <= addr_r;
          end else if (code[OPB_DIN]) begin
            kind <= K_WR; oe_r <= 1'b1; state <= S_FETCH;
          end else begin
            kind <= K_RD; oe_r <= 1'b0; state <= S_WAITRB;
          end
        end
        S_WAITRB: if (rb_q[1]) begin
          pstart <= 1'b1; state <= S_PULSE;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          dq_r <= ram_q; pstart <= 1'b1; state <= S_PULSE;
        end
        S_PULSE: if (p_fin) begin
          if (kind == K_CMD && is_id) begin
            kind <= K_ADDR; dq_r <= 8'h00; pstart <= 1'b1;
          end else if ((kind == K_ADDR && is_id) || (kind == K_CMD && is_stat)) begin
            kind <= K_RD; oe_r <= 1'b0; idx <= '0; pstart <= 1'b1;
          end else if ((kind == K_WR || kind == K_RD) && idx != last_idx) begin
            idx <= idx + 1'b1;
            if (kind == K_WR) state <= S_FETCH;
            else pstart <= 1'b1;
          end else begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1; oe_r <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  nand_pulse_gen #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_pulse (
    .clk(clk), .rst(rst), .clr(soft_rst), .start(pstart),
    .active(p_active), .low(p_low), .last_low(p_last_low), .fin(p_fin)
  );

  // ---------------- buffer ----------------
  logic [BUF_AW-1:0] eng_addr, ram_addr;
  logic              ram_we;
  logic [7:0]        ram_wdata;

  nand_buf_map #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .AREAS(AREAS),
    .AREA_W(AREA_W), .IW(IW), .AW(BUF_AW)
  ) u_map (
    .area(area_l), .idx(idx), .spare_only(sp_l), .main_only(is_id || is_stat),
    .addr(eng_addr)
  );

  wire eng_we = (state == S_PULSE) && (kind == K_RD) && p_last_low;

  assign ram_addr  = busy ? eng_addr : hb_addr;
  assign ram_we    = busy ? eng_we   : hb_we;
  assign ram_wdata = busy ? nf_dq_i  : hb_wdata;

  nand_buf_ram #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );
  assign hb_rdata = ram_q;

  // ---------------- device pins ----------------
  assign nf_we_n  = !(p_low && kind != K_RD);
  assign nf_re_n  = !(p_low && kind == K_RD);
  assign nf_cle   = p_active && kind == K_CMD;
  assign nf_ale   = p_active && kind == K_ADDR;
  assign nf_ce_n  = !(busy || force_ce);
  assign nf_dq_o  = dq_r;
  assign nf_dq_oe = oe_r;
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
  parameter int LOW_CLKS = 2
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic nf_ce_n,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic abort_wr
);
  // R1: outputs idle on the first cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && nf_we_n && nf_re_n && !nf_cle && !nf_ale));

  // R2 / R3: latch enables are exclusive
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));

  // R4: strobes never overlap
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n));

  // R4: a strobe that falls stays low in the next cycle
  generate if (LOW_CLKS >= 2) begin : g_width
    assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(nf_we_n) |=> !nf_we_n);
    assert_re_width_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(nf_re_n) |=> !nf_re_n);
  end endgenerate

  // R10: flag stays clear while running, and only rises out of a running op
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  assert_done_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R12: chip enable is active under every strobe
  assert_ce_cover_R12: assert property (@(posedge clk) disable iff (rst)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  // R13: abort returns the engine to idle
  assert_abort_idle_R13: assert property (@(posedge clk) disable iff (rst)
    abort_wr |=> (!busy && !done && nf_we_n && nf_re_n));
endmodule

bind nand_op_seq nand_op_seq_chk #(.LOW_CLKS(LOW_CLKS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .nf_ce_n(nf_ce_n),
  .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .abort_wr(reg_we && (reg_addr == 3'd3) && reg_wdata[6])
);

// File: tb/nand_op_seq_bench.sv
module nand_op_seq_bench;
  localparam int MAIN  = 32;
  localparam int SPARE = 8;
  localparam int AREAS = 4;
  localparam int IDB   = 4;
  localparam int LOWC  = 2;
  localparam int HIGHC = 2;
  localparam int BUSYC = 15;
  localparam int XFER  = MAIN + SPARE;
  localparam int BUFB  = AREAS * XFER;
  localparam int AW    = $clog2(BUFB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic          hb_we = 1'b0;
  logic [AW-1:0] hb_addr = '0;
  logic [7:0]    hb_wdata = '0;
  logic [7:0]    hb_rdata;
  logic busy, done, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_o, nf_dq_i;
  logic nf_rb_n;

  nand_op_seq #(.MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .AREAS(AREAS),
                .ID_BYTES(IDB), .LOW_CLKS(LOWC), .HIGH_CLKS(HIGHC)) u_nand_op_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .busy(busy), .done(done), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n));

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(int s, int j);
    return 8'(j * 5 + s * 17 + 1);
  endfunction
  function automatic logic [7:0] hp(int a);
    return 8'(a * 3 + 11);
  endfunction
  function automatic int bm(int area, int j, bit sp);
    if (sp) return AREAS * MAIN + area * SPARE + j;
    if (j < MAIN) return area * MAIN + j;
    return AREAS * MAIN + area * SPARE + j - MAIN;
  endfunction

  // ---------------- behavioural device ----------------
  typedef enum int {M_DATA, M_ID, M_STAT} dmode_e;
  dmode_e dmode = M_DATA;
  int ptr = 0, seed = 0, busy_cnt = 0, rel_cyc = 0, re_while_busy = 0;
  int ncmd = 0, naddr = 0, ndata = 0, width_bad = 0;
  logic [7:0] cmd_log [64];
  logic [7:0] addr_log [64];
  logic [7:0] data_log [64];
  logic prev_we = 1'b1, prev_re = 1'b1, had_rise = 1'b0;
  int lo_we = 0, lo_re = 0, hi_cnt = 0;

  assign nf_rb_n = (busy_cnt == 0);
  assign nf_dq_i = !nf_re_n ? ((dmode == M_ID) ? 8'(8'hA0 + ptr) :
                               (dmode == M_STAT) ? 8'hE0 : pat(seed, ptr)) : 8'h00;

  always @(negedge clk) begin
    if (prev_we && !nf_we_n || prev_re && !nf_re_n) begin
      if (had_rise && hi_cnt < HIGHC) width_bad++;
      hi_cnt = 0;
    end
    if (prev_re && !nf_re_n && busy_cnt != 0) re_while_busy++;
    if (!nf_we_n) lo_we++;
    if (!nf_re_n) lo_re++;
    if (nf_we_n && nf_re_n) hi_cnt++;
    if (!prev_we && nf_we_n) begin
      if (lo_we != LOWC) width_bad++;
      lo_we = 0; had_rise = 1'b1;
      if (nf_cle) begin
        cmd_log[ncmd] = nf_dq_o; ncmd++;
        ptr = 0;
        dmode = (nf_dq_o == 8'h90) ? M_ID : (nf_dq_o == 8'h70) ? M_STAT : M_DATA;
        if (nf_dq_o == 8'h30) begin seed++; busy_cnt = BUSYC; end
      end else if (nf_ale) begin
        addr_log[naddr] = nf_dq_o; naddr++;
      end else begin
        data_log[ndata] = nf_dq_o; ndata++;
      end
    end
    if (!prev_re && nf_re_n) begin
      if (lo_re != LOWC) width_bad++;
      lo_re = 0; had_rise = 1'b1; ptr++;
    end
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) rel_cyc = cyc;
    end
    prev_we = nf_we_n; prev_re = nf_re_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic hb_wr(input int a, input int d);
    @(negedge clk); hb_we = 1'b1; hb_addr = AW'(a); hb_wdata = 8'(d);
    @(negedge clk); hb_we = 1'b0;
  endtask

  task automatic hb_rd(input int a, output logic [7:0] d);
    @(negedge clk); hb_addr = AW'(a);
    @(negedge clk); d = hb_rdata;
  endtask

  task automatic wait_done(output int dcyc);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R10 timeout", 0, 1);
    dcyc = cyc;
  endtask

  task automatic run_op(input int code, output int dcyc);
    wr_reg(4, code);
    wait_done(dcyc);
    wr_reg(4, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int dc, bad, c0, a0, first_a, first_e;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale,
        "R1 reset state", {busy, done, nf_ce_n, nf_we_n, nf_re_n}, 5'b00111);

    // R2 command cycle
    wr_reg(0, 16'h00A5);
    run_op(16'h0001, dc);
    chk(ncmd == 1 && cmd_log[0] == 8'hA5 && naddr == 0, "R2 command latched", cmd_log[0], 8'hA5);
    // R3 address cycle
    wr_reg(1, 16'h005A);
    run_op(16'h0002, dc);
    chk(naddr == 1 && addr_log[0] == 8'h5A && ncmd == 1, "R3 address latched", addr_log[0], 8'h5A);

    // R10 done holds until cleared
    wr_reg(4, 16'h0001);
    wait_done(dc);
    repeat (20) @(negedge clk);
    chk(done && !busy, "R10 done held", done, 1);
    wr_reg(4, 16'h8000);
    chk(done, "R10 write with bit15 set keeps flag", done, 1);
    wr_reg(4, 16'h0000);
    chk(!done, "R10 cleared by writing zero", done, 0);

    // R11 non-one-hot code
    c0 = ncmd; a0 = naddr;
    wr_reg(4, 16'h0003);
    chk(!busy, "R11 bad code starts nothing", busy, 0);
    repeat (10) @(negedge clk);
    chk(ncmd == c0 && naddr == a0 && !done, "R11 bad code no bus cycle", ncmd, c0);

    // R5 data input sweep over all areas
    for (int a = 0; a < BUFB; a++) hb_wr(a, hp(a));
    for (int ar = 0; ar < AREAS; ar++) begin
      ndata = 0; bad = 0; first_a = 0; first_e = 0;
      wr_reg(2, ar); wr_reg(3, 0);
      run_op(16'h0004, dc);
      for (int j = 0; j < XFER; j++)
        if (data_log[j] !== hp(bm(ar, j, 1'b0))) begin
          if (bad == 0) begin first_a = data_log[j]; first_e = hp(bm(ar, j, 1'b0)); end
          bad++;
        end
      chk(ndata == XFER, "R5 data-in byte count", ndata, XFER);
      chk(bad == 0, "R5 data-in order and area", first_a, first_e);
    end
    // R7 spare-only data input
    ndata = 0; bad = 0;
    wr_reg(2, 2); wr_reg(3, 16'h0004);
    run_op(16'h0004, dc);
    for (int j = 0; j < SPARE; j++) if (data_log[j] !== hp(bm(2, j, 1'b1))) bad++;
    chk(ndata == SPARE && bad == 0, "R7 spare-only data-in", ndata, SPARE);

    // R6 data output sweep, each after a busy period
    for (int ar = 0; ar < AREAS; ar++) begin
      re_while_busy = 0;
      wr_reg(0, 16'h0030); wr_reg(3, 0);
      run_op(16'h0001, dc);
      wr_reg(2, ar);
      wr_reg(4, 16'h0008);
      wait_done(dc);
      wr_reg(4, 0);
      chk(re_while_busy == 0, "R6 no read strobe while busy", re_while_busy, 0);
      chk(dc > rel_cyc, "R6 done after ready", dc, rel_cyc);
      chk(ptr == XFER, "R6 read byte count", ptr, XFER);
      bad = 0; first_a = 0; first_e = 0;
      for (int j = 0; j < XFER; j++) begin
        hb_rd(bm(ar, j, 1'b0), d);
        if (d !== pat(seed, j)) begin
          if (bad == 0) begin first_a = d; first_e = pat(seed, j); end
          bad++;
        end
      end
      chk(bad == 0, "R6 R5 buffer placement", first_a, first_e);
    end

    // R7 spare-only data output, main untouched
    c0 = seed;
    wr_reg(0, 16'h0030);
    run_op(16'h0001, dc);
    wr_reg(2, 3); wr_reg(3, 16'h0004);
    run_op(16'h0008, dc);
    chk(ptr == SPARE, "R7 spare-only read count", ptr, SPARE);
    bad = 0;
    for (int j = 0; j < SPARE; j++) begin
      hb_rd(bm(3, j, 1'b1), d);
      if (d !== pat(seed, j)) bad++;
    end
    chk(bad == 0, "R7 spare bytes placed", bad, 0);
    hb_rd(3 * MAIN, d);
    chk(d == pat(c0, 0), "R7 main area untouched", d, pat(c0, 0));

    // R8 read ID into area 0
    c0 = ncmd; a0 = naddr;
    wr_reg(2, 0); wr_reg(3, 0);
    run_op(16'h0010, dc);
    chk(ncmd == c0 + 1 && cmd_log[c0] == 8'h90, "R8 ID command", cmd_log[c0], 8'h90);
    chk(naddr == a0 + 1 && addr_log[a0] == 8'h00, "R8 ID address", addr_log[a0], 0);
    bad = 0;
    for (int j = 0; j < IDB; j++) begin
      hb_rd(j, d);
      if (d !== 8'(8'hA0 + j)) bad++;
    end
    chk(bad == 0, "R8 ID bytes at area start", bad, 0);

    // R9 read status into area 1
    c0 = ncmd;
    wr_reg(2, 1);
    run_op(16'h0020, dc);
    chk(cmd_log[c0] == 8'h70, "R9 status command", cmd_log[c0], 8'h70);
    hb_rd(MAIN, d);
    chk(d == 8'hE0, "R9 status byte placement", d, 8'hE0);

    // R11 trigger during a busy wait is ignored
    wr_reg(0, 16'h0030);
    run_op(16'h0001, dc);
    c0 = ncmd;
    wr_reg(4, 16'h0008);
    wr_reg(0, 16'h0055);
    wr_reg(4, 16'h0001);
    chk(busy, "R11 still busy", busy, 1);
    wait_done(dc);
    wr_reg(4, 0);
    repeat (10) @(negedge clk);
    chk(ncmd == c0 && ptr == XFER, "R11 busy trigger ignored", ncmd, c0);

    // R12 forced chip enable
    wr_reg(3, 16'h0080);
    chk(!nf_ce_n, "R12 forced enable", nf_ce_n, 0);
    wr_reg(3, 16'h0000);
    chk(nf_ce_n, "R12 idle released", nf_ce_n, 1);

    // R13 abort during busy wait
    wr_reg(0, 16'h0030);
    run_op(16'h0001, dc);
    wr_reg(4, 16'h0008);
    wr_reg(3, 16'h0040);
    chk(!busy && !done && nf_re_n, "R13 abort to idle", busy, 0);
    repeat (40) @(negedge clk);
    chk(ptr == 0 && !done, "R13 no reads after abort", ptr, 0);

    // R4 strobe widths seen across the whole run
    chk(width_bad == 0, "R4 strobe timing", width_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule